// File: doc/BRIEF.md
# Hot-Swap Circuit Breaker Controller

This block is the digital decision core of a hot-swap gate driver. It takes two kinds of comparator results from the load sense resistor: one over-current flag, and a small set of fast-trip flags at three increasing levels. It also takes an enable input and a set of configuration straps. From these it decides, every clock cycle, whether the external pass transistor's gate drive may stay on. It also drives an active-low fault indication and a flag that shows the gate is being held in a current-limiting window. Analog sensing, gate slew shaping and real non-volatile storage are handled elsewhere.

The over-current flag must persist through a programmable filter window before the breaker opens. A strap-selected fast-trip level opens it at once. When regulation is enabled, the filter is replaced by a regulation window. This window re-arms whenever the current falls back, and it opens the breaker only if the over-current outlasts the programmed timeout.

After a trip, the breaker either re-closes by itself after a retry delay, or stays open until the enable input is dropped and raised again. An optional sticky fault latch can also be enabled. Once set, it keeps the gate off through resets and enable toggles, until a dedicated factory-clear input is applied.

Top module: `hotswap_breaker`

## Requirements
- R1: After `rst_n` releases with `enable_i` low, `gate_en_o`=0, `fault_n_o`=1 and `reg_active_o`=0. Every asynchronous input passes a two-flop synchronizer. As a result, a change on `enable_i`, `over_i` or `quick_i` first affects the outputs on the third rising clock edge after it is applied. For example, raising `enable_i` closes the gate on that third edge.
- R2: With regulation off, the breaker trips once the synchronized `over_i` has been high for `cfg_filt_dly`+1 consecutive cycles. Any low cycle restarts the count from zero.
- R3: `cfg_quick_sel` encoding: 2'b00 selects `quick_i[0]`, 2'b01 selects `quick_i[1]`, 2'b10 selects `quick_i[2]`, and 2'b11 disables the fast trip. Only the selected flag trips the breaker. It trips on the first cycle that flag is seen, with no filter delay.
- R4: With `cfg_reg_en`=1, an over-current while the gate is on enters regulation one cycle after the synchronized flag rises. In regulation, `reg_active_o`=1 and `gate_en_o` stays 1. The filter delay is not used.
- R5: In regulation, the breaker trips if the flag stays high for `cfg_reg_tmo`+1 cycles. If the flag drops earlier, `reg_active_o` clears and the next over-current starts a full, fresh window. The fast trip still acts immediately during regulation.
- R6: A trip forces `gate_en_o`=0 and `fault_n_o`=0 from the edge on which it occurs.
- R7: With `cfg_latched`=0, the gate re-closes `cfg_retry_dly`+1 cycles after the trip edge. If the over-current is still present at that point, the breaker trips again under R2.
- R8: With `cfg_latched`=1, a tripped breaker stays open regardless of elapsed time. A low followed by a high on the synchronized enable clears the fault and re-closes the gate.
- R9: With `cfg_pfl_en`=1, any trip sets a sticky latch. While the latch is set, `gate_en_o`=0 and `fault_n_o`=0 through `rst_n` pulses and enable toggles. Only `factory_clr_i` high at a clock edge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| factory_clr_i | input | 1 | Synchronous clear of the sticky fault latch |
| enable_i | input | 1 | Enable / toggle input (asynchronous) |
| over_i | input | 1 | Over-current comparator flag (asynchronous) |
| quick_i | input | 3 | Fast-trip comparator flags, lowest level in bit 0 (asynchronous) |
| cfg_filt_dly | input | CNT_W | Filter delay in cycles |
| cfg_quick_sel | input | 2 | Fast-trip level select (see R3) |
| cfg_reg_en | input | 1 | Enable regulation window |
| cfg_reg_tmo | input | CNT_W | Regulation timeout in cycles |
| cfg_latched | input | 1 | 1 = latched mode, 0 = auto-retry |
| cfg_retry_dly | input | CNT_W | Auto-retry delay in cycles |
| cfg_pfl_en | input | 1 | Enable sticky fault latch |
| gate_en_o | output | 1 | Gate drive enable |
| fault_n_o | output | 1 | Fault flag, active low |
| reg_active_o | output | 1 | Regulation window active |

## Verification
The filter is tried with a pulse of exactly `cfg_filt_dly` cycles, with two sub-threshold pulses separated by a gap, and with a sustained over-current. These cases separate a correct restarting count from a cumulative count and from an off-by-one threshold. Fast-trip flags are driven one level at a time under each select code, including the off code. This shows that only the selected level acts, and that it bypasses both the filter and an active regulation window. The regulation window is driven once with a drop before timeout followed by a fresh over-current, and once held to expiry, which shows that the timer re-arms. The recovery paths are each exercised with a persisting fault: auto-retry, latched hold with enable toggle, and the sticky latch against reset and toggle.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ON   = 3'd1,
    ST_REG  = 3'd2,
    ST_WAIT = 3'd3,
    ST_HOLD = 3'd4
  } hsb_state_e;

  localparam int unsigned QLVL = 3;

  typedef enum logic [1:0] {
    QSEL_LOW  = 2'b00,
    QSEL_MID  = 2'b01,
    QSEL_HIGH = 2'b10,
    QSEL_OFF  = 2'b11
  } hsb_qsel_e;

endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hsb_qsel.sv
module hsb_qsel
  import hsb_pkg::*;
(
  input  logic [QLVL-1:0] quick_s,
  input  logic [1:0]      sel,
  output logic            hit
);
  logic [QLVL-1:0] mask;

  for (genvar i = 0; i < QLVL; i++) begin : g_mask
    assign mask[i] = (sel == 2'(i));
  end

  assign hit = |(quick_s & mask);
endmodule

// File: rtl/hsb_fsm.sv
module hsb_fsm
  import hsb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_s,
  input  logic             over_s,
  input  logic             qt_hit,
  input  logic [CNT_W-1:0] cfg_filt_dly,
  input  logic             cfg_reg_en,
  input  logic [CNT_W-1:0] cfg_reg_tmo,
  input  logic             cfg_latched,
  input  logic [CNT_W-1:0] cfg_retry_dly,
  output hsb_state_e       state_o,
  output logic             trip_o
);
  hsb_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  hsb_state_e       trip_dest;

  assign trip_dest = cfg_latched ? ST_HOLD : ST_WAIT;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    trip_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (en_s) st_d = ST_ON;
      end
      ST_ON: begin
        if (!en_s) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else if (qt_hit) begin
          st_d   = trip_dest;
          cnt_d  = '0;
          trip_o = 1'b1;
        end else if (over_s) begin
          if (cfg_reg_en) begin
            st_d  = ST_REG;
            cnt_d = '0;
          end else if (cnt_q == cfg_filt_dly) begin
            st_d   = trip_dest;
            cnt_d  = '0;
            trip_o = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else begin
          cnt_d = '0;
        end
      end
      ST_REG: begin
        if (!en_s) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else if (qt_hit) begin
          st_d   = trip_dest;
          cnt_d  = '0;
          trip_o = 1'b1;
        end else if (!over_s) begin
          st_d  = ST_ON;
          cnt_d = '0;
        end else if (cnt_q == cfg_reg_tmo) begin
          st_d   = trip_dest;
          cnt_d  = '0;
          trip_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (!en_s) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else if (cnt_q == cfg_retry_dly) begin
          st_d  = ST_ON;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HOLD: begin
        cnt_d = '0;
        if (!en_s) st_d = ST_IDLE;
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/hsb_sticky.sv
module hsb_sticky (
  input  logic clk,
  input  logic factory_clr_i,
  input  logic trip,
  input  logic cfg_pfl_en,
  output logic latched_o
);
  logic pfl_q;

  always_ff @(posedge clk) begin
    if (factory_clr_i)           pfl_q <= 1'b0;
    else if (trip && cfg_pfl_en) pfl_q <= 1'b1;
  end

  assign latched_o = pfl_q;
endmodule

// File: rtl/hotswap_breaker.sv
module hotswap_breaker
  import hsb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             factory_clr_i,
  input  logic             enable_i,
  input  logic             over_i,
  input  logic [2:0]       quick_i,
  input  logic [CNT_W-1:0] cfg_filt_dly,
  input  logic [1:0]       cfg_quick_sel,
  input  logic             cfg_reg_en,
  input  logic [CNT_W-1:0] cfg_reg_tmo,
  input  logic             cfg_latched,
  input  logic [CNT_W-1:0] cfg_retry_dly,
  input  logic             cfg_pfl_en,
  output logic             gate_en_o,
  output logic             fault_n_o,
  output logic             reg_active_o
);
  localparam int unsigned SYNC_W = QLVL + 2;

  logic [SYNC_W-1:0] raw_in, sync_out;
  logic              en_s, over_s, qt_hit, trip, pfl_q;
  logic [QLVL-1:0]   quick_s;
  hsb_state_e        st_q;

  assign raw_in = {enable_i, over_i, quick_i};

  hsb_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  assign en_s    = sync_out[SYNC_W-1];
  assign over_s  = sync_out[SYNC_W-2];
  assign quick_s = sync_out[QLVL-1:0];

  hsb_qsel u_qsel (.quick_s(quick_s), .sel(cfg_quick_sel), .hit(qt_hit));

  hsb_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .over_s(over_s), .qt_hit(qt_hit),
    .cfg_filt_dly(cfg_filt_dly), .cfg_reg_en(cfg_reg_en),
    .cfg_reg_tmo(cfg_reg_tmo), .cfg_latched(cfg_latched),
    .cfg_retry_dly(cfg_retry_dly), .state_o(st_q), .trip_o(trip)
  );

  hsb_sticky u_sticky (
    .clk(clk), .factory_clr_i(factory_clr_i), .trip(trip),
    .cfg_pfl_en(cfg_pfl_en), .latched_o(pfl_q)
  );

  assign gate_en_o    = ((st_q == ST_ON) || (st_q == ST_REG)) && !pfl_q;
  assign fault_n_o    = !((st_q == ST_WAIT) || (st_q == ST_HOLD) || pfl_q);
  assign reg_active_o = (st_q == ST_REG) && !pfl_q;
endmodule

// File: rtl/hsb_checker.sv
module hsb_checker
  import hsb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       factory_clr_i,
  input logic       en_s,
  input logic       qt_hit,
  input logic       pfl_q,
  input hsb_state_e st_q,
  input logic       gate_en_o,
  input logic       fault_n_o,
  input logic       reg_active_o
);
  assert_fault_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n_o |-> !gate_en_o);

  assert_reg_keeps_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_active_o |-> gate_en_o);

  assert_quick_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (((st_q == ST_ON) || (st_q == ST_REG)) && en_s && qt_hit) |=> !gate_en_o);

  assert_hold_no_reclose_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD) |=> ((st_q == ST_HOLD) || (st_q == ST_IDLE)));

  assert_sticky_persists_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pfl_q && !factory_clr_i) |=> (pfl_q && !gate_en_o && !fault_n_o));

  assert_close_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en_o) |-> $past(en_s));
endmodule

bind hotswap_breaker hsb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .factory_clr_i(factory_clr_i), .en_s(en_s),
  .qt_hit(qt_hit), .pfl_q(pfl_q), .st_q(st_q), .gate_en_o(gate_en_o),
  .fault_n_o(fault_n_o), .reg_active_o(reg_active_o)
);

// File: tb/test_hotswap_breaker.sv
module test_hotswap_breaker;
  localparam int CNT_W = 16;
  localparam int F = 20;
  localparam int T = 30;
  localparam int R = 40;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             factory_clr_i = 1'b1;
  logic             enable_i = 1'b0;
  logic             over_i = 1'b0;
  logic [2:0]       quick_i = 3'b000;
  logic [CNT_W-1:0] cfg_filt_dly = CNT_W'(F);
  logic [1:0]       cfg_quick_sel = 2'b01;
  logic             cfg_reg_en = 1'b0;
  logic [CNT_W-1:0] cfg_reg_tmo = CNT_W'(T);
  logic             cfg_latched = 1'b0;
  logic [CNT_W-1:0] cfg_retry_dly = CNT_W'(R);
  logic             cfg_pfl_en = 1'b0;
  logic             gate_en_o, fault_n_o, reg_active_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hotswap_breaker #(.CNT_W(CNT_W)) i_hotswap_breaker (
    .clk(clk), .rst_n(rst_n), .factory_clr_i(factory_clr_i),
    .enable_i(enable_i), .over_i(over_i), .quick_i(quick_i),
    .cfg_filt_dly(cfg_filt_dly), .cfg_quick_sel(cfg_quick_sel),
    .cfg_reg_en(cfg_reg_en), .cfg_reg_tmo(cfg_reg_tmo),
    .cfg_latched(cfg_latched), .cfg_retry_dly(cfg_retry_dly),
    .cfg_pfl_en(cfg_pfl_en), .gate_en_o(gate_en_o),
    .fault_n_o(fault_n_o), .reg_active_o(reg_active_o)
  );

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic recover();
    over_i = 1'b0; quick_i = 3'b000; enable_i = 1'b0;
    wcyc(5);
    enable_i = 1'b1;
    wcyc(5);
  endtask

  task automatic t_reset();
    wcyc(2);
    chk("R1", "gate after reset", gate_en_o, 0);
    chk("R1", "fault_n after reset", fault_n_o, 1);
    chk("R1", "reg_active after reset", reg_active_o, 0);
    enable_i = 1'b1;
    wcyc(2);
    chk("R1", "gate before 3rd edge", gate_en_o, 0);
    wcyc(1);
    chk("R1", "gate on 3rd edge", gate_en_o, 1);
  endtask

  task automatic t_filter();
    over_i = 1'b1; wcyc(F); over_i = 1'b0;
    wcyc(6);
    chk("R2", "pulse of F cycles no trip", gate_en_o, 1);
    over_i = 1'b1; wcyc(F - 2); over_i = 1'b0; wcyc(1);
    over_i = 1'b1; wcyc(F - 2); over_i = 1'b0;
    wcyc(6);
    chk("R2", "split pulses restart count", gate_en_o, 1);
    over_i = 1'b1;
    wcyc(F + 2);
    chk("R2", "gate before filter end", gate_en_o, 1);
    wcyc(1);
    chk("R2", "trip after F+1 cycles", gate_en_o, 0);
    chk("R6", "fault_n low on trip", fault_n_o, 0);
    // R7: auto-retry with fault still present
    wcyc(R);
    chk("R7", "still open before retry", gate_en_o, 0);
    wcyc(1);
    chk("R7", "reclosed after R+1", gate_en_o, 1);
    chk("R7", "fault cleared on reclose", fault_n_o, 1);
    wcyc(F);
    chk("R7", "gate before re-trip", gate_en_o, 1);
    wcyc(1);
    chk("R7", "re-trip with fault present", gate_en_o, 0);
    recover();
  endtask

  task automatic quick_case(input logic [1:0] sel, input logic [2:0] pat,
                            input int exp_trip, input string what);
    cfg_quick_sel = sel;
    quick_i = pat;
    wcyc(2);
    chk("R3", {what, " before"}, gate_en_o, 1);
    wcyc(1);
    chk("R3", what, gate_en_o, exp_trip ? 0 : 1);
    wcyc(4);
    chk("R3", {what, " settled"}, gate_en_o, exp_trip ? 0 : 1);
    recover();
  endtask

  task automatic t_quick();
    quick_case(2'b01, 3'b010, 1, "sel01 level1 trips");
    quick_case(2'b00, 3'b001, 1, "sel00 level0 trips");
    quick_case(2'b10, 3'b011, 0, "sel10 ignores lower levels");
    quick_case(2'b10, 3'b100, 1, "sel10 level2 trips");
    quick_case(2'b11, 3'b111, 0, "sel11 disabled");
    cfg_quick_sel = 2'b01;
  endtask

  task automatic t_regulate();
    cfg_reg_en = 1'b1;
    over_i = 1'b1;
    wcyc(2);
    chk("R4", "reg_active before entry", reg_active_o, 0);
    wcyc(1);
    chk("R4", "reg_active on entry", reg_active_o, 1);
    wcyc(F + 5);
    chk("R4", "filter not used in regulation", gate_en_o, 1);
    over_i = 1'b0;
    wcyc(5);
    chk("R5", "reg_active clears on drop", reg_active_o, 0);
    chk("R5", "gate stays after drop", gate_en_o, 1);
    over_i = 1'b1;
    wcyc(T + 3);
    chk("R5", "fresh window gate on before timeout", gate_en_o, 1);
    wcyc(1);
    chk("R5", "trip at timeout", gate_en_o, 0);
    chk("R5", "reg_active off after trip", reg_active_o, 0);
    recover();
    over_i = 1'b1;
    wcyc(6);
    quick_i = 3'b010;
    wcyc(2);
    chk("R5", "regulating before quick", reg_active_o, 1);
    wcyc(1);
    chk("R5", "quick trips during regulation", gate_en_o, 0);
    cfg_reg_en = 1'b0;
    recover();
  endtask

  task automatic t_latched();
    cfg_latched = 1'b1;
    quick_i = 3'b010;
    wcyc(5);
    quick_i = 3'b000;
    wcyc(R + 20);
    chk("R8", "latched stays open", gate_en_o, 0);
    chk("R8", "latched fault held", fault_n_o, 0);
    enable_i = 1'b0;
    wcyc(4);
    chk("R8", "fault clears on enable low", fault_n_o, 1);
    enable_i = 1'b1;
    wcyc(4);
    chk("R8", "reclosed after toggle", gate_en_o, 1);
    cfg_latched = 1'b0;
  endtask

  task automatic t_sticky();
    cfg_pfl_en = 1'b1;
    quick_i = 3'b010;
    wcyc(5);
    quick_i = 3'b000;
    wcyc(R + 10);
    chk("R9", "sticky blocks retry", gate_en_o, 0);
    enable_i = 1'b0; wcyc(5); enable_i = 1'b1; wcyc(5);
    chk("R9", "sticky survives toggle gate", gate_en_o, 0);
    chk("R9", "sticky survives toggle fault", fault_n_o, 0);
    rst_n = 1'b0; wcyc(3); rst_n = 1'b1; wcyc(6);
    chk("R9", "sticky survives reset gate", gate_en_o, 0);
    chk("R9", "sticky survives reset fault", fault_n_o, 0);
    cfg_pfl_en = 1'b0;
    factory_clr_i = 1'b1; wcyc(1); factory_clr_i = 1'b0;
    wcyc(1);
    chk("R9", "factory clear restores gate", gate_en_o, 1);
    chk("R9", "factory clear restores fault", fault_n_o, 1);
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wcyc(3);
    rst_n = 1'b1;
    wcyc(1);
    factory_clr_i = 1'b0;
    t_reset();
    t_filter();
    t_quick();
    t_regulate();
    t_latched();
    t_sticky();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule